// File: doc/BRIEF.md
# I2C Transfer Clock and Bit Sequencer

This block is the master-side clocking engine of a simple two-wire serial interface. A small control word selects how many data bits a transfer carries (one to eight), whether an acknowledge clock follows them, and which SCL rate to use. A start strobe launches a burst of SCL pulses. Transmit data leaves most significant bit first and changes only while SCL is low. Receive data is sampled as SCL rises. During the acknowledge clock the data output is released high and the sampled line level is kept as the acknowledge status.

The SCL period is the system clock divided by 2^n + 8, with n running from 5 to 11 for clock-select codes 0 to 6. Code 7 is reserved and never starts a burst. A software-reset input aborts a burst at once. The lowest readback bit of the control word reports 0 while that reset is held and 1 otherwise. This bit shares its position with the lowest clock-select bit, which software can write but cannot read back. Bus conditions, arbitration, addressing and pad drivers are handled elsewhere.

Top module: `i2c_burst_engine`

## Requirements
- R1: The length field ctl_wdata[6:4] sets the data bit count. Code 0 gives 8 bits and codes 1 to 7 give 1 to 7 bits. With acknowledge disabled, a transfer has exactly that many SCL rising edges.
- R2: When the acknowledge-enable bit ctl_wdata[3] is 1, one extra SCL pulse follows the data. During that pulse sda_o is 1, and the level of sda_i at its rising edge appears on ack_bit.
- R3: For clock-select code s (ctl_wdata[2:0], 0 to 6), the SCL period is 2^(s+5)+8 system cycles, split into equal low and high halves.
- R4: A start strobe while clock-select is 7 is ignored. busy stays 0 and scl_o stays 1.
- R5: Transmit bits go out from tx_byte[7] downward, one per SCL pulse. sda_o never changes while SCL stays high during a transfer.
- R6: Each data bit is sampled from sda_i at the SCL rising edge and shifted into rx_byte from the LSB side. After a transfer of L bits, rx_byte holds those bits in its low L positions, with the first bit highest, and zeros above them.
- R7: ctl_rdata reads {length[2:0], ack enable, clock-select[2:1], monitor}. After reset it reads 7'h01.
- R8: ctl_rdata[0] reads 0 while soft_rst is 1 and 1 otherwise, whatever was written to clock-select bit 0.
- R9: soft_rst aborts a transfer. One cycle later busy is 0 and scl_o and sda_o are 1, and no done pulse is produced.
- R10: busy rises in the cycle after an accepted start. done is a single-cycle pulse after the last SCL falling edge, and busy falls in the same cycle. While idle, scl_o and sda_o are 1.
- R11: A start strobe that arrives while busy is 1 has no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software reset; aborts a transfer while high |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 7 | Control word: length [6:4], ack enable [3], clock select [2:0] |
| ctl_rdata | output | 7 | Control readback; bit 0 is the software-reset monitor |
| start | input | 1 | Starts a burst when idle |
| tx_byte | input | 8 | Transmit data, latched at start |
| sda_i | input | 1 | Sampled data line |
| scl_o | output | 1 | Serial clock, high when idle |
| sda_o | output | 1 | Data line drive, 1 means released |
| rx_byte | output | 8 | Received data bits |
| ack_bit | output | 1 | Level sampled during the acknowledge clock |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Control readback is combinational from registered fields, so the bench reads it at the falling edge after a write, and the monitor bit at the falling edge after soft_rst changes. SCL, the data output and busy are all registers. SCL first drops in the cycle after the start edge and then toggles every 2^(s+4)+4 cycles. The bench therefore samples at every falling edge and measures rise-to-rise and rise-to-fall spacing rather than assuming absolute times. rx_byte and ack_bit are only compared once done has been seen. done is expected one half-period after the final SCL fall and is checked to be low on the next sample.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    localparam int LEN_W  = 3;
    localparam int SEL_W  = 3;
    localparam int CTL_W  = LEN_W + 1 + SEL_W;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 4;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LOW  = 2'd1,
        SQ_HIGH = 2'd2,
        SQ_TAIL = 2'd3
    } sq_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             ack_en;
        logic [SEL_W-1:0] sel;
    } cfg_t;

endpackage

// File: rtl/i2cb_cfg_reg.sv
module i2cb_cfg_reg
    import i2cb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output cfg_t             cfg,
    output logic [CTL_W-1:0] rdata
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            cfg_d = cfg_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Lowest position reports the software-reset monitor, not the written bit
    assign rdata = {cfg_q.len, cfg_q.ack_en, cfg_q.sel[SEL_W-1:1], ~soft_rst};
    assign cfg   = cfg_q;

endmodule

// File: rtl/i2cb_half_div.sv
module i2cb_half_div
    import i2cb_pkg::*;
#(
    parameter int N_BASE = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int N_MAX = N_BASE + (2 ** SEL_W) - 2;
    localparam int CNT_W = N_MAX;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t d_d, d_q;
    logic [CNT_W-1:0] half_m1;

    // Half of (2^n + 8) is 2^(n-1) + 4; the counter runs from that minus one down to zero
    always_comb begin
        half_m1 = CNT_W'((1 << (N_BASE - 1 + int'(sel))) + 3);
    end

    assign tick = run && (d_q.cnt == '0);

    always_comb begin
        d_d = d_q;
        if (load) begin
            d_d.cnt = half_m1;
        end else if (run) begin
            if (d_q.cnt == '0) begin
                d_d.cnt = half_m1;
            end else begin
                d_d.cnt = d_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

endmodule

// File: rtl/i2cb_bit_seq.sv
module i2cb_bit_seq
    import i2cb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              start,
    input  cfg_t              cfg,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              sda_i,
    input  logic              tick,
    output logic              load,
    output logic              busy,
    output logic              done,
    output logic              scl,
    output logic              sda,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ack_bit
);

    typedef struct packed {
        sq_state_e         st;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  dlen;
        logic [IDX_W-1:0]  total;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] rx;
        logic              ack;
        logic              scl;
        logic              sda;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;
    logic             accept;
    logic [IDX_W-1:0] len_bits;
    logic [IDX_W-1:0] nxt_idx;

    always_comb begin
        len_bits = (cfg.len == '0) ? IDX_W'(BYTE_W) : IDX_W'(cfg.len);
        accept   = (s_q.st == SQ_IDLE) && start && !soft_rst && (cfg.sel != '1);
        nxt_idx  = s_q.idx + IDX_W'(1);
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (accept) begin
                    s_d.st    = SQ_LOW;
                    s_d.dlen  = len_bits;
                    s_d.total = len_bits + IDX_W'(cfg.ack_en);
                    s_d.idx   = '0;
                    s_d.sh    = tx_byte;
                    s_d.rx    = '0;
                    s_d.scl   = 1'b0;
                    s_d.sda   = tx_byte[BYTE_W-1];
                end
            end
            SQ_LOW: begin
                if (tick) begin
                    s_d.st  = SQ_HIGH;
                    s_d.scl = 1'b1;
                    if (s_q.idx < s_q.dlen) begin
                        s_d.rx = {s_q.rx[BYTE_W-2:0], sda_i};
                    end else begin
                        s_d.ack = sda_i;
                    end
                end
            end
            SQ_HIGH: begin
                if (tick) begin
                    s_d.scl = 1'b0;
                    if (nxt_idx == s_q.total) begin
                        s_d.st = SQ_TAIL;
                    end else begin
                        s_d.st  = SQ_LOW;
                        s_d.idx = nxt_idx;
                        s_d.sh  = s_q.sh << 1;
                        s_d.sda = (nxt_idx < s_q.dlen) ? s_q.sh[BYTE_W-2] : 1'b1;
                    end
                end
            end
            SQ_TAIL: begin
                if (tick) begin
                    s_d.st   = SQ_IDLE;
                    s_d.scl  = 1'b1;
                    s_d.sda  = 1'b1;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
        if (soft_rst) begin
            s_d.st   = SQ_IDLE;
            s_d.scl  = 1'b1;
            s_d.sda  = 1'b1;
            s_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= SQ_IDLE;
            s_q.scl   <= 1'b1;
            s_q.sda   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign load    = accept;
    assign busy    = (s_q.st != SQ_IDLE);
    assign done    = s_q.done;
    assign scl     = s_q.scl;
    assign sda     = s_q.sda;
    assign rx_byte = s_q.rx;
    assign ack_bit = s_q.ack;

endmodule

// File: rtl/i2c_burst_engine.sv
module i2c_burst_engine
    import i2cb_pkg::*;
#(
    parameter int N_BASE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              sda_i,
    output logic              scl_o,
    output logic              sda_o,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ack_bit,
    output logic              busy,
    output logic              done
);

    cfg_t cfg_w;
    logic tick_w;
    logic load_w;

    i2cb_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr       (ctl_wr),
        .wdata    (ctl_wdata),
        .cfg      (cfg_w),
        .rdata    (ctl_rdata)
    );

    i2cb_half_div #(.N_BASE(N_BASE)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_w),
        .run   (busy),
        .sel   (cfg_w.sel),
        .tick  (tick_w)
    );

    i2cb_bit_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .start    (start),
        .cfg      (cfg_w),
        .tx_byte  (tx_byte),
        .sda_i    (sda_i),
        .tick     (tick_w),
        .load     (load_w),
        .busy     (busy),
        .done     (done),
        .scl      (scl_o),
        .sda      (sda_o),
        .rx_byte  (rx_byte),
        .ack_bit  (ack_bit)
    );

endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       start,
    input logic [2:0] sel,
    input logic       busy,
    input logic       done,
    input logic       scl_o,
    input logic       sda_o,
    input logic [6:0] ctl_rdata
);

    p_idle_lines_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_o && sda_o));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_busy_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !soft_rst && sel != 3'b111) |=> busy);

    p_reserved_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && sel == 3'b111) |=> !busy);

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy && !done && scl_o && sda_o));

    p_monitor_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> !ctl_rdata[0]);

    p_monitor_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |-> ctl_rdata[0]);

    p_sda_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && $past(busy) && busy && !$past(soft_rst)) |-> $stable(sda_o));

endmodule

bind i2c_burst_engine i2cb_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .start     (start),
    .sel       (cfg_w.sel),
    .busy      (busy),
    .done      (done),
    .scl_o     (scl_o),
    .sda_o     (sda_o),
    .ctl_rdata (ctl_rdata)
);

// File: tb/i2c_burst_engine_tb.sv
module i2c_burst_engine_tb;

    localparam int CLK_P = 10;

    typedef struct packed {
        logic [2:0] len;
        logic       ack;
        logic [2:0] sel;
        logic [7:0] tx;
        logic [7:0] rx;
        logic       ackv;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 1'b0, 3'd0, 8'hA5, 8'h3C, 1'b0},
        '{3'd0, 1'b1, 3'd0, 8'h5A, 8'hC3, 1'b0},
        '{3'd1, 1'b0, 3'd1, 8'h80, 8'h01, 1'b0},
        '{3'd1, 1'b1, 3'd0, 8'h00, 8'h01, 1'b1},
        '{3'd3, 1'b1, 3'd2, 8'hE0, 8'h05, 1'b0},
        '{3'd7, 1'b0, 3'd0, 8'hFE, 8'h55, 1'b0},
        '{3'd5, 1'b1, 3'd1, 8'hB8, 8'h1A, 1'b1},
        '{3'd4, 1'b0, 3'd0, 8'h9F, 8'h0F, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [6:0] ctl_wdata = '0;
    logic [6:0] ctl_rdata;
    logic       start = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       sda_i = 1'b1;
    logic       scl_o, sda_o, ack_bit, busy, done;
    logic [7:0] rx_byte;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    i2c_burst_engine u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .start(start), .tx_byte(tx_byte), .sda_i(sda_i),
        .scl_o(scl_o), .sda_o(sda_o), .rx_byte(rx_byte), .ack_bit(ack_bit),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [6:0] w);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = w;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        int L, pulses, rises, guard, dones, high_viol;
        int cyc, r0, r1, f0;
        logic prev_scl, prev_sda, ack_seen;
        logic [7:0] cap;
        L = (v.len == 3'd0) ? 8 : int'(v.len);
        pulses = L + int'(v.ack);
        rises = 0; guard = 0; dones = 0; high_viol = 0;
        cyc = 0; r0 = -1; r1 = -1; f0 = -1;
        cap = '0; ack_seen = 1'b0;
        write_ctl({v.len, v.ack, v.sel});
        tx_byte = v.tx;
        sda_i = v.rx[L-1];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
        prev_scl = 1'b1;
        prev_sda = sda_o;
        while (guard < 20000) begin
            if (done) begin
                dones++;
                break;
            end
            if (!prev_scl && scl_o) begin
                if (rises < L) cap = {cap[6:0], sda_o};
                else ack_seen = sda_o;
                if (rises == 0) r0 = cyc;
                if (rises == 1) r1 = cyc;
                rises++;
            end
            if (prev_scl && !scl_o && r0 >= 0 && f0 < 0) f0 = cyc;
            if (prev_scl && scl_o && sda_o != prev_sda) high_viol++;
            sda_i = (rises < L) ? v.rx[L-1-rises] : v.ackv;
            prev_scl = scl_o;
            prev_sda = sda_o;
            @(negedge clk);
            cyc++;
            guard++;
        end
        chk(dones == 1, "R10 done seen", dones, 1);
        chk(rises == pulses, v.ack ? "R2 pulse count with ack" : "R1 pulse count", rises, pulses);
        chk(cap == (v.tx >> (8 - L)), "R5 transmit bits", int'(cap), int'(v.tx >> (8 - L)));
        chk(high_viol == 0, "R5 sda steady while scl high", high_viol, 0);
        chk(rx_byte == (v.rx & 8'((1 << L) - 1)), "R6 receive bits", int'(rx_byte),
            int'(v.rx & 8'((1 << L) - 1)));
        chk(f0 - r0 == (1 << (v.sel + 4)) + 4, "R3 high half", f0 - r0, (1 << (v.sel + 4)) + 4);
        if (pulses >= 2)
            chk(r1 - r0 == (1 << (v.sel + 5)) + 8, "R3 period", r1 - r0, (1 << (v.sel + 5)) + 8);
        if (v.ack) begin
            chk(ack_seen == 1'b1, "R2 sda released in ack clock", int'(ack_seen), 1);
            chk(ack_bit == v.ackv, "R2 ack captured", int'(ack_bit), int'(v.ackv));
        end
        @(negedge clk);
        chk(!done && !busy && scl_o && sda_o, "R10 single done and idle lines",
            int'({done, busy, scl_o, sda_o}), 3);
    endtask

    initial begin
        int n_bad, rises;
        logic prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctl_rdata == 7'h01, "R7 reset readback", int'(ctl_rdata), 1);
        chk(scl_o && sda_o && !busy && !done, "R10 reset idle lines",
            int'({scl_o, sda_o, busy, done}), 12);

        write_ctl(7'h7F);
        chk(ctl_rdata == 7'h7F, "R7 readback all ones", int'(ctl_rdata), 8'h7F);
        write_ctl(7'h2A);
        chk(ctl_rdata == 7'h2B, "R8 bit0 shows monitor", int'(ctl_rdata), 8'h2B);

        foreach (VECS[i]) run_vec(VECS[i]);

        // R4 reserved clock select
        write_ctl(7'h07);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n_bad = 0;
        repeat (60) begin
            @(negedge clk);
            if (busy || !scl_o || done) n_bad++;
        end
        chk(n_bad == 0, "R4 reserved select ignored", n_bad, 0);

        // R11 start while busy
        write_ctl(7'h20);
        tx_byte = 8'hC0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        tx_byte = 8'h3F;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rises = 1;
        prev = scl_o;
        for (int g = 0; g < 2000 && !done; g++) begin
            @(negedge clk);
            if (!prev && scl_o && !done) rises++;
            prev = scl_o;
        end
        chk(rises == 2, "R11 second start ignored", rises, 2);

        // R9 / R8 software reset abort
        write_ctl(7'h00);
        tx_byte = 8'h00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        chk(ctl_rdata[0] == 1'b0, "R8 monitor low in soft reset", int'(ctl_rdata[0]), 0);
        chk(!busy && scl_o && sda_o, "R9 abort lines", int'({busy, scl_o, sda_o}), 3);
        n_bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (done || busy) n_bad++;
        end
        soft_rst = 1'b0;
        @(negedge clk);
        chk(n_bad == 0, "R9 no done after abort", n_bad, 0);
        chk(ctl_rdata[0] == 1'b1, "R8 monitor back high", int'(ctl_rdata[0]), 1);
        n_bad = 0;
        repeat (60) begin
            @(negedge clk);
            if (done || busy || !scl_o) n_bad++;
        end
        chk(n_bad == 0, "R9 stays idle after abort", n_bad, 0);

        run_vec(VECS[3]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R10 actual=%0d expected=0", 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule